// File: doc/BRIEF.md
# Asynchronous Byte Configuration Port

This block takes configuration bytes from an external host that has no clock in common with the chip. The host uses two chip selects of opposite polarity, a write strobe, a read strobe and an 8-bit data bus. The port brings all of these into the local clock domain. When a write strobe ends, the port stores the byte in a single-entry buffer and passes it to a downstream consumer through a valid/ready handshake.

While the buffer is full, the port reports busy. It does this in two ways: on a dedicated ready output, and on the top data line when the host performs a read. If a read and a write are both asserted, the write wins. An active-low init input keeps the port in a wait state until it is released.

Top module: `cfg_byte_port`

## Requirements
- R1: The port is selected only when `sel0_n` is 0 and `sel1` is 1. With any other pair, the write and read strobes have no effect: no byte is captured and `bus_oe` stays 0.
- R2: A selected write (`wr_n` low) captures the value `bus_in` held while the strobe was low. The byte appears on `byte_data`, and `byte_valid` rises at the third rising clock edge after `wr_n` returns high. A change of `bus_in` together with the strobe release does not alter the stored byte.
- R3: One write strobe stores exactly one byte, however many cycles it stays low.
- R4: A selected read (`rd_n` low, `wr_n` high) makes `bus_oe` equal 8'h80, so only bit 7 is driven. `bus_out[7]` is 1 when the port is ready and 0 when it is busy.
- R5: When `wr_n` and `rd_n` are both low while selected, the write is captured and `bus_oe` stays 8'h00.
- R6: `rdy` equals the read status. It is 0 from the capture of a byte until the consumer accepts that byte (`byte_valid` and `byte_ready` both high at a clock edge). It is 1 right after that edge.
- R7: A write that ends while the buffer is full is dropped. `byte_data` keeps the earlier byte and `byte_valid` stays 1.
- R8: While `init_n` is 0, `rdy` is 0 and writes are not captured.
- R9: While `rst` is high, `byte_valid`, `rdy` and `bus_oe` are 0. Once `rst` is low and `init_n` is high, `rdy` rises within three cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| init_n | input | 1 | Active-low hold in wait state |
| sel0_n | input | 1 | Active-low chip select |
| sel1 | input | 1 | Active-high chip select |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low read strobe |
| bus_in | input | 8 | Host data bus, incoming value |
| byte_ready | input | 1 | Consumer accepts the buffered byte |
| bus_out | output | 8 | Data bus drive value (status in bit 7) |
| bus_oe | output | 8 | Per-bit drive enable for the data bus |
| rdy | output | 1 | Another byte may be written |
| byte_data | output | 8 | Buffered byte |
| byte_valid | output | 1 | Buffer holds a byte for the consumer |

## Verification
The bench applies all sixteen combinations of the two chip selects and the two strobes to an empty buffer. This separates the deselected cases from a plain write, a plain read and an overlapping write and read: each combination has its own expected pair of capture and drive enable. A run of distinct data values, with the bus changed at the moment the strobe is released, shows whether the port captures the byte held during the strobe or a value sampled too late. Further sequences cover a long strobe, a second write into a full buffer, a read while busy, and writes during the init hold. These tell a correct busy path apart from one that overwrites the buffer or loses the status.

// File: rtl/cfg_byte_port.sv
module cfg_byte_port #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          init_n,
  input  logic          sel0_n,
  input  logic          sel1,
  input  logic          wr_n,
  input  logic          rd_n,
  input  logic [DW-1:0] bus_in,
  input  logic          byte_ready,
  output logic [DW-1:0] bus_out,
  output logic [DW-1:0] bus_oe,
  output logic          rdy,
  output logic [DW-1:0] byte_data,
  output logic          byte_valid
);
  localparam int TOP = DW - 1;

  logic [1:0]    s_sel0, s_sel1, s_wr, s_rd, s_init;
  logic [DW-1:0] s_dat0, s_dat1;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_sel0 <= 2'b11;
      s_sel1 <= 2'b00;
      s_wr   <= 2'b11;
      s_rd   <= 2'b11;
      s_init <= 2'b00;
      s_dat0 <= '0;
      s_dat1 <= '0;
    end else begin
      s_sel0 <= {s_sel0[0], sel0_n};
      s_sel1 <= {s_sel1[0], sel1};
      s_wr   <= {s_wr[0], wr_n};
      s_rd   <= {s_rd[0], rd_n};
      s_init <= {s_init[0], init_n};
      s_dat0 <= bus_in;
      s_dat1 <= s_dat0;
    end
  end

  logic sel, live, wr_on, rd_on, wr_on_q, capture;
  logic [DW-1:0] hold;

  assign sel   = !s_sel0[1] && s_sel1[1];
  assign live  = s_init[1];
  assign wr_on = sel && !s_wr[1] && live;
  assign rd_on = sel && !s_rd[1] && s_wr[1];

  assign rdy     = live && !byte_valid;
  assign capture = wr_on_q && !wr_on && rdy;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_on_q    <= 1'b0;
      hold       <= '0;
      byte_data  <= '0;
      byte_valid <= 1'b0;
    end else begin
      wr_on_q <= wr_on;
      if (wr_on) hold <= s_dat1;
      if (capture) begin
        byte_data  <= hold;
        byte_valid <= 1'b1;
      end else if (byte_valid && byte_ready) begin
        byte_valid <= 1'b0;
      end
    end
  end

  assign bus_out = {rdy, {TOP{1'b0}}};
  assign bus_oe  = {rd_on, {TOP{1'b0}}};
endmodule

module cfg_byte_port_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          sel0_n,
  input logic          sel1,
  input logic          wr_n,
  input logic          init_n,
  input logic          byte_ready,
  input logic          rdy,
  input logic [DW-1:0] bus_oe,
  input logic [DW-1:0] byte_data,
  input logic          byte_valid
);
  assert_oe_needs_select_R1: assert property (@(posedge clk) disable iff (rst)
    bus_oe[DW-1] |-> $past(!sel0_n && sel1, 2));

  assert_write_beats_read_R5: assert property (@(posedge clk) disable iff (rst)
    bus_oe[DW-1] |-> $past(wr_n, 2));

  assert_capture_when_ready_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(byte_valid) |-> $past(rdy));

  assert_full_holds_R7: assert property (@(posedge clk) disable iff (rst)
    (byte_valid && !byte_ready) |=> (byte_valid && $stable(byte_data)));

  assert_accept_frees_R6: assert property (@(posedge clk) disable iff (rst)
    (byte_valid && byte_ready) |=> !byte_valid);

  assert_init_blocks_R8: assert property (@(posedge clk) disable iff (rst)
    (!init_n && $past(!init_n) && $past(!init_n, 2)) |-> !rdy);
endmodule

bind cfg_byte_port cfg_byte_port_chk #(.DW(DW)) chk (.*);

// File: tb/cfg_byte_port_test.sv
module cfg_byte_port_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic init_n = 1'b1, sel0_n = 1'b1, sel1 = 1'b0, wr_n = 1'b1, rd_n = 1'b1;
  logic [7:0] bus_in = 8'h00;
  logic byte_ready = 1'b0;
  logic [7:0] bus_out, bus_oe, byte_data;
  logic rdy, byte_valid;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  cfg_byte_port uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic idle();
    sel0_n = 1'b1; sel1 = 1'b0; wr_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic consume();
    byte_ready = 1'b1; cyc(1); byte_ready = 1'b0; cyc(1);
  endtask

  task automatic put(input logic [7:0] d, input int len);
    sel0_n = 1'b0; sel1 = 1'b1; bus_in = d; wr_n = 1'b0;
    cyc(len);
    wr_n = 1'b1; bus_in = ~d;
    cyc(1); idle(); cyc(4);
  endtask

  initial begin
    cyc(3);
    chk("R9 valid in reset", byte_valid, 0);
    chk("R9 rdy in reset", rdy, 0);
    chk("R9 oe in reset", bus_oe, 8'h00);
    rst = 1'b0;
    cyc(3);
    chk("R9 rdy after reset", rdy, 1);

    for (int c = 0; c < 16; c++) begin
      logic e_sel, e_wr, e_oe;
      sel0_n = c[0]; sel1 = c[1]; wr_n = c[2]; rd_n = c[3];
      bus_in = 8'h30 + 8'(c);
      e_sel = !c[0] && c[1];
      e_wr  = e_sel && !c[2];
      e_oe  = e_sel && !c[3] && c[2];
      cyc(4);
      chk(e_oe ? "R4 read oe" : (e_sel && !c[3] ? "R5 overlap oe" : "R1 oe"), bus_oe, e_oe ? 8'h80 : 8'h00);
      if (e_oe) chk("R4 status ready", bus_out[7], 1);
      idle(); cyc(4);
      chk(e_wr ? (c[3] ? "R2 capture" : "R5 overlap write") : "R1 no capture", byte_valid, e_wr);
      if (e_wr) begin
        chk("R2 data", byte_data, 8'h30 + 8'(c));
        chk("R6 rdy busy", rdy, 0);
        consume();
        chk("R6 rdy after accept", rdy, 1);
      end
    end

    // R2 exact latency, data changed at release
    sel0_n = 1'b0; sel1 = 1'b1; bus_in = 8'hC3; wr_n = 1'b0;
    cyc(4);
    wr_n = 1'b1; bus_in = 8'h3C;
    cyc(2);
    chk("R2 not yet valid", byte_valid, 0);
    cyc(1);
    chk("R2 valid on third edge", byte_valid, 1);
    chk("R2 held data", byte_data, 8'hC3);
    idle();
    byte_ready = 1'b1;
    chk("R6 rdy low before accept", rdy, 0);
    cyc(1); byte_ready = 1'b0;
    chk("R6 rdy right after accept", rdy, 1);
    chk("R6 valid cleared", byte_valid, 0);

    for (int k = 0; k < 10; k++) begin
      logic [7:0] d;
      d = (k < 8) ? 8'(1 << k) : (k == 8 ? 8'h00 : 8'hFF);
      put(d, 3);
      chk("R2 pattern", byte_data, d);
      consume();
    end

    put(8'h5A, 25);
    chk("R3 long strobe data", byte_data, 8'h5A);
    consume();
    cyc(6);
    chk("R3 single byte", byte_valid, 0);

    put(8'hA1, 3);
    put(8'hB2, 3);
    chk("R7 kept byte", byte_data, 8'hA1);
    chk("R7 still valid", byte_valid, 1);
    sel0_n = 1'b0; sel1 = 1'b1; rd_n = 1'b0;
    cyc(4);
    chk("R4 oe busy", bus_oe, 8'h80);
    chk("R4 status busy", bus_out[7], 0);
    idle(); consume();

    init_n = 1'b0; cyc(3);
    chk("R8 rdy low", rdy, 0);
    put(8'h77, 3);
    chk("R8 no capture", byte_valid, 0);
    init_n = 1'b1; cyc(3);
    chk("R8 rdy after release", rdy, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1500000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule